// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a 32-bit register bus and an array of one-time-programmable fuse words. Software picks a word with an address register and a bit with a bit-select register. It supplies the value to burn through a data-in register. Three separate enable registers must all be switched on before the controller lets the addressed word appear on a read-only data-out register. Writing the write-enable register with its bit 0 set programs exactly one fuse bit. A written-once flag kept for every bit turns away any second attempt on the same bit and raises a one-cycle reject pulse.

Reset returns the array to its blank state, in which every word reads all ones. Reset also clears all written-once flags and loads two words: a configurable serial value at a fixed word index, and its bitwise complement at the next index. The array depth is `2**ADDR_W` words. The production figure is 4096 words (`ADDR_W = 12`). The default build uses 64 words so that it elaborates quickly.

The bus is a single-cycle request interface. Read data is registered and appears in the cycle after the read request.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: A read of data-out (offset 0x00) returns the addressed fuse word when bit 0 of chip-enable (0x18), bit 0 of strobe (0x1C) and bit 0 of trim (0x20) are all 1. If any of the three is 0, the read returns 0x000000FF.
- R2: A write to data-out (0x00) changes nothing: the fuse array and every register read back as they were before the write.
- R3: The word-address register (0x08) stores only its low ADDR_W bits, and reads back with all higher bits zero.
- R4: The write-enable register (0x04) stores only bit 0. A write to it programs a fuse bit only when the written bit 0 is 1 and the whole redundancy-select register (0x14) is zero. Any other write to it programs nothing and leaves that bit free to be programmed later.
- R5: Programming sets the bit selected by bit-select[4:0] (0x0C), within the addressed word, to data-in bit 0 (0x10). All other bits of the array are left as they were.
- R6: Each fuse bit has a written-once flag, which a successful program sets. When a program is attempted on a bit whose flag is already set, the array is left unchanged and `prog_reject` is high for the single cycle after that write.
- R7: After reset every fuse word reads 0xFFFFFFFF and every written-once flag is clear, so each bit can be programmed once again.
- R8: After reset, word SERIAL_IDX holds SERIAL and word SERIAL_IDX+1 holds ~SERIAL.
- R9: Only whole-word accesses are accepted: byte enables 4'hF and offset bits [1:0] equal to zero. A rejected access, or an access at an offset of 0x3C or above, reads 0 and drops its write.
- R10: The remaining registers store and return the full 32-bit value written: bit-select 0x0C, data-in 0x10, redundancy-select 0x14, chip-enable 0x18, strobe 0x1C, trim 0x20, clock 0x24, program 0x28, test-control 0x2C, test-mode 0x30, test-repeat 0x34 and test-read 0x38. All registers reset to zero.
- R11: Read data appears on `rdata` in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_off | input | 8 | Byte offset of the register |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| prog_reject | output | 1 | One-cycle pulse after a rejected reprogram attempt |

## Verification
The assertions check the following on every cycle:
- a data-out read returns 0xFF while the read gate is closed, and returns the addressed word while it is open;
- a malformed or unmapped read returns zero;
- `rdata` holds its value between read requests;
- each successful program leaves the flag of its bit set;
- every reject pulse follows a write of bit 0 to write-enable;
- every program comes from such a write while redundancy-select is zero.

Other behaviour can only be shown by the bench's scenarios:
- the contents of the array after sequences of programs;
- the refusal to reprogram the same bit with either value;
- the preloaded serial words;
- the address masking;
- the restoration of blank contents and clear flags by a mid-run reset.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  localparam int NREG = 15;

  // Register identifiers; the identifier equals the word offset (req_off[5:2]).
  typedef enum logic [3:0] {
    RG_DOUT   = 4'd0,
    RG_WEN    = 4'd1,
    RG_ADDR   = 4'd2,
    RG_BITSEL = 4'd3,
    RG_DIN    = 4'd4,
    RG_REDSEL = 4'd5,
    RG_CEN    = 4'd6,
    RG_STROBE = 4'd7,
    RG_TRIM   = 4'd8,
    RG_CLK    = 4'd9,
    RG_PROG   = 4'd10,
    RG_TCTL   = 4'd11,
    RG_TMODE  = 4'd12,
    RG_TREP   = 4'd13,
    RG_TREAD  = 4'd14
  } reg_id_e;

  localparam logic [31:0] DOUT_CLOSED = 32'h0000_00FF;

  // Whole-word, aligned access test.
  function automatic logic full_access(logic [3:0] be, logic [1:0] lo);
    return (be == 4'hF) && (lo == 2'b00);
  endfunction

  // Offset maps onto an implemented register.
  function automatic logic id_in_range(logic [7:0] off);
    return ({2'b00, off[7:2]} < 8'(NREG));
  endfunction

  function automatic reg_id_e id_of(logic [7:0] off);
    return reg_id_e'(off[5:2]);
  endfunction

  // Bits a register keeps when written.
  function automatic logic [31:0] keep_mask(int id, int addr_w);
    logic [31:0] m;
    if (id == int'(RG_DOUT))      m = 32'h0;
    else if (id == int'(RG_WEN))  m = 32'h1;
    else if (id == int'(RG_ADDR)) m = (addr_w >= 32) ? 32'hFFFF_FFFF
                                                     : ((32'h1 << addr_w) - 32'h1);
    else                          m = 32'hFFFF_FFFF;
    return m;
  endfunction

  // All three read enables must be on.
  function automatic logic read_gate(logic cen, logic stb, logic trim);
    return cen & stb & trim;
  endfunction

  // Replace one bit of a word.
  function automatic logic [31:0] put_bit(logic [31:0] word, logic [4:0] idx, logic v);
    logic [31:0] one_hot;
    one_hot = 32'h1 << idx;
    return v ? (word | one_hot) : (word & ~one_hot);
  endfunction

  // Reset content of word idx.
  function automatic logic [31:0] reset_word(int idx, int serial_idx, logic [31:0] serial);
    logic [31:0] w;
    if (idx == serial_idx)          w = serial;
    else if (idx == serial_idx + 1) w = ~serial;
    else                            w = 32'hFFFF_FFFF;
    return w;
  endfunction

endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_fuse_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  reg_id_e               wr_id,
  input  logic [31:0]           wr_data,
  output logic [NREG-1:0][31:0] regs_q
);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [31:0] MASK = keep_mask(g, ADDR_W);
      localparam reg_id_e     ID   = reg_id_e'(g);
      if (g == int'(RG_DOUT)) begin : g_none
        // Read-only slot: nothing stored, writes have no target.
        assign regs_q[g] = 32'h0;
      end else begin : g_store
        logic [31:0] q;
        always_ff @(posedge clk) begin
          if (!rst_n)                      q <= 32'h0;
          else if (wr_en && wr_id == ID)   q <= wr_data & MASK;
        end
        assign regs_q[g] = q;
      end
    end
  endgenerate

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_fuse_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          SERIAL_IDX = 60,   // must be below 2**ADDR_W - 1
  parameter logic [31:0] SERIAL     = 32'hA5C3_0F96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        bit_idx,
  input  logic              din_bit,
  output logic [31:0]       sel_word,
  output logic              sel_flag,
  output logic              commit,
  output logic              reject
);

  localparam int WORDS = 1 << ADDR_W;

  logic [31:0] fuse_w [WORDS];
  logic [31:0] once_w [WORDS];

  logic [31:0] sel_once;
  assign sel_word = fuse_w[addr];
  assign sel_once = once_w[addr];
  assign sel_flag = sel_once[bit_idx];

  assign commit = prog_req & ~sel_flag;
  assign reject = prog_req &  sel_flag;

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      localparam logic [31:0] INIT = reset_word(g, SERIAL_IDX, SERIAL);
      logic [31:0] word_q;
      logic [31:0] flag_q;
      logic        hit;
      assign hit = commit && (addr == ADDR_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          word_q <= INIT;
          flag_q <= 32'h0;
        end else if (hit) begin
          word_q <= put_bit(word_q, bit_idx, din_bit);
          flag_q <= put_bit(flag_q, bit_idx, 1'b1);
        end
      end
      assign fuse_w[g] = word_q;
      assign once_w[g] = flag_q;
    end
  endgenerate

endmodule

// File: rtl/otp_rd_path.sv
module otp_rd_path
  import otp_fuse_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic                  rd_ok,
  input  reg_id_e               rd_id,
  input  logic [NREG-1:0][31:0] regs,
  input  logic                  gate_open,
  input  logic [31:0]           fuse_word,
  output logic [31:0]           rdata_q
);

  logic [31:0] nxt;

  always_comb begin
    if (!rd_ok)                nxt = 32'h0;
    else if (rd_id == RG_DOUT) nxt = gate_open ? fuse_word : DOUT_CLOSED;
    else                       nxt = regs[rd_id];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= 32'h0;
    else if (rd_en) rdata_q <= nxt;
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          SERIAL_IDX = 60,
  parameter logic [31:0] SERIAL     = 32'hA5C3_0F96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_off,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic [31:0] rdata,
  output logic        prog_reject
);

  // Request decode
  logic    acc_ok, wr_en, rd_en;
  reg_id_e req_id;
  assign req_id = id_of(req_off);
  assign acc_ok = req_valid && full_access(req_be, req_off[1:0]) && id_in_range(req_off);
  assign wr_en  = acc_ok && req_write;
  assign rd_en  = req_valid && !req_write;

  // Control registers
  logic [NREG-1:0][31:0] regs;
  otp_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_id   (req_id),
    .wr_data (req_wdata),
    .regs_q  (regs)
  );

  // Named internal events
  logic redsel_zero, gate_open, prog_req;
  logic [31:0] sel_word;
  logic sel_flag, commit, reject;
  logic [31:0] addr_reg, bitsel_reg, din_reg;

  assign addr_reg    = regs[RG_ADDR];
  assign bitsel_reg  = regs[RG_BITSEL];
  assign din_reg     = regs[RG_DIN];
  assign redsel_zero = (regs[RG_REDSEL] == 32'h0);
  assign gate_open   = read_gate(regs[RG_CEN][0], regs[RG_STROBE][0], regs[RG_TRIM][0]);
  assign prog_req    = wr_en && (req_id == RG_WEN) && req_wdata[0] && redsel_zero;

  otp_fuse_array #(
    .ADDR_W     (ADDR_W),
    .SERIAL_IDX (SERIAL_IDX),
    .SERIAL     (SERIAL)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_req (prog_req),
    .addr     (addr_reg[ADDR_W-1:0]),
    .bit_idx  (bitsel_reg[4:0]),
    .din_bit  (din_reg[0]),
    .sel_word (sel_word),
    .sel_flag (sel_flag),
    .commit   (commit),
    .reject   (reject)
  );

  otp_rd_path u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_ok     (acc_ok),
    .rd_id     (req_id),
    .regs      (regs),
    .gate_open (gate_open),
    .fuse_word (sel_word),
    .rdata_q   (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) prog_reject <= 1'b0;
    else        prog_reject <= reject;
  end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_off,
  input logic [3:0]  req_be,
  input logic        wen_bit,
  input logic [31:0] rdata,
  input logic        prog_reject,
  input logic        gate_open,
  input logic        redsel_zero,
  input logic        commit,
  input logic        sel_flag,
  input logic [31:0] sel_word
);

  logic rd_req, rd_dout, rd_bad, wen_wr;
  assign rd_req  = req_valid && !req_write;
  assign rd_dout = rd_req && req_be == 4'hF && req_off == 8'h00;
  assign rd_bad  = rd_req && (req_be != 4'hF || req_off[1:0] != 2'b00 || req_off >= 8'h3C);
  assign wen_wr  = req_valid && req_write && req_be == 4'hF && req_off == 8'h04;

  AST_DOUT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dout && !gate_open) |=> (rdata == 32'h0000_00FF)); // R1
  AST_DOUT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dout && gate_open) |=> (rdata == $past(sel_word))); // R1
  AST_BAD_ACCESS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> (rdata == 32'h0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata)); // R11
  AST_FLAG_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> sel_flag); // R6
  AST_REJECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_reject |-> $past(wen_wr && wen_bit)); // R6
  AST_COMMIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wen_wr && wen_bit && redsel_zero)); // R4

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_off     (req_off),
  .req_be      (req_be),
  .wen_bit     (req_wdata[0]),
  .rdata       (rdata),
  .prog_reject (prog_reject),
  .gate_open   (gate_open),
  .redsel_zero (redsel_zero),
  .commit      (commit),
  .sel_flag    (sel_flag),
  .sel_word    (sel_word)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;

  localparam logic [31:0] SER  = 32'h1357_2468;
  localparam int          SIDX = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_off = 8'h0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = 32'h0;
  logic [31:0] rdata;
  logic        prog_reject;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  otp_fuse_ctrl #(.ADDR_W(6), .SERIAL_IDX(SIDX), .SERIAL(SER)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_be(req_be), .req_wdata(req_wdata),
    .rdata(rdata), .prog_reject(prog_reject)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] off, input logic [31:0] d,
                        input logic [3:0] be, output logic rej);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_off = off; req_wdata = d; req_be = be;
    @(posedge clk); #5;
    rej = prog_reject;
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
  endtask

  task automatic bus_rd(input logic [7:0] off, input logic [3:0] be,
                        output logic [31:0] d, output logic rej);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_off = off; req_be = be;
    @(posedge clk); #5;
    d = rdata; rej = prog_reject;
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    logic r;
    bus_wr(off, d, 4'hF, r);
  endtask

  function automatic logic [31:0] rd_val(input logic [31:0] d);
    return d;
  endfunction

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {req tag number, is_write, offset, data, expected readback}
  localparam int NV = 20;
  localparam logic [76:0] VEC [NV] = '{
    {4'd10, 1'b1, 8'h24, 32'hDEAD_BEEF, 32'h0},
    {4'd10, 1'b0, 8'h24, 32'h0,         32'hDEAD_BEEF},
    {4'd10, 1'b1, 8'h28, 32'h1357_9BDF, 32'h0},
    {4'd10, 1'b0, 8'h28, 32'h0,         32'h1357_9BDF},
    {4'd10, 1'b1, 8'h2C, 32'h8000_0001, 32'h0},
    {4'd10, 1'b0, 8'h2C, 32'h0,         32'h8000_0001},
    {4'd10, 1'b1, 8'h30, 32'h0F0F_0F0F, 32'h0},
    {4'd10, 1'b0, 8'h30, 32'h0,         32'h0F0F_0F0F},
    {4'd10, 1'b1, 8'h34, 32'hFFFF_FFFF, 32'h0},
    {4'd10, 1'b0, 8'h34, 32'h0,         32'hFFFF_FFFF},
    {4'd10, 1'b1, 8'h38, 32'hA5A5_A5A5, 32'h0},
    {4'd10, 1'b0, 8'h38, 32'h0,         32'hA5A5_A5A5},
    {4'd10, 1'b1, 8'h0C, 32'hFFFF_FFE3, 32'h0},
    {4'd10, 1'b0, 8'h0C, 32'h0,         32'hFFFF_FFE3},
    {4'd10, 1'b1, 8'h14, 32'h0000_0002, 32'h0},
    {4'd10, 1'b0, 8'h14, 32'h0,         32'h0000_0002},
    {4'd3,  1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
    {4'd3,  1'b0, 8'h08, 32'h0,         32'h0000_003F},
    {4'd4,  1'b1, 8'h04, 32'hFFFF_FFFE, 32'h0},
    {4'd4,  1'b0, 8'h04, 32'h0,         32'h0000_0000}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic        r;
    logic [31:0] w5;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: R10 registers zero, R1 gate closed
    bus_rd(8'h18, 4'hF, d, r); check("R10 reset chip-enable", d, 32'h0);
    bus_rd(8'h00, 4'hF, d, r); check("R1 reset dout closed", d, 32'hFF);
    check("R6 reset no reject", {31'b0, r}, 32'h0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VEC[i];
      if (v[72]) wr(v[71:64], v[63:32]);
      else begin
        bus_rd(v[71:64], 4'hF, d, r);
        check($sformatf("R%0d table entry %0d", v[76:73], i), d, v[31:0]);
      end
    end
    wr(8'h14, 32'h0);

    // Open the read gate
    wr(8'h18, 32'h1); wr(8'h1C, 32'h1); wr(8'h20, 32'h1);

    // R8 serial words
    wr(8'h08, 32'(SIDX));
    bus_rd(8'h00, 4'hF, d, r); check("R8 serial word", d, SER);
    wr(8'h08, 32'(SIDX + 1));
    bus_rd(8'h00, 4'hF, d, r); check("R8 complement word", d, ~SER);

    // R7 blank word
    wr(8'h08, 32'd5);
    bus_rd(8'h00, 4'hF, d, r); check("R7 blank word", d, 32'hFFFF_FFFF);

    // R1 each enable alone closes the gate
    wr(8'h20, 32'hFFFF_FFFE);
    bus_rd(8'h00, 4'hF, d, r); check("R1 trim off", d, 32'hFF);
    wr(8'h20, 32'h1); wr(8'h1C, 32'h2);
    bus_rd(8'h00, 4'hF, d, r); check("R1 strobe off", d, 32'hFF);
    wr(8'h1C, 32'h1); wr(8'h18, 32'h0);
    bus_rd(8'h00, 4'hF, d, r); check("R1 chip-enable off", d, 32'hFF);
    wr(8'h18, 32'h1);

    // R5 program bit 3 of word 5 to 0
    w5 = 32'hFFFF_FFFF;
    wr(8'h0C, 32'd3); wr(8'h10, 32'h0);
    bus_wr(8'h04, 32'h1, 4'hF, r);
    check("R6 first program not rejected", {31'b0, r}, 32'h0);
    w5 = w5 & ~(32'h1 << 3);
    bus_rd(8'h00, 4'hF, d, r); check("R5 bit cleared", d, w5);
    bus_rd(8'h04, 4'hF, d, r); check("R4 wen readback bit0", d, 32'h1);

    // R6 second attempt on the same bit
    wr(8'h10, 32'h1);
    bus_wr(8'h04, 32'h1, 4'hF, r);
    check("R6 reprogram pulse", {31'b0, r}, 32'h1);
    bus_rd(8'h00, 4'hF, d, r);
    check("R6 word unchanged", d, w5);
    check("R6 pulse one cycle", {31'b0, r}, 32'h0);

    // R4 redundancy-select nonzero blocks programming
    wr(8'h0C, 32'd7); wr(8'h10, 32'h0); wr(8'h14, 32'h1);
    bus_wr(8'h04, 32'h1, 4'hF, r);
    check("R4 redsel no reject", {31'b0, r}, 32'h0);
    bus_rd(8'h00, 4'hF, d, r); check("R4 redsel blocks", d, w5);
    wr(8'h14, 32'h0);
    bus_wr(8'h04, 32'h1, 4'hF, r);
    check("R4 bit still free", {31'b0, r}, 32'h0);
    w5 = w5 & ~(32'h1 << 7);
    bus_rd(8'h00, 4'hF, d, r); check("R4 program after redsel cleared", d, w5);

    // R4 write-enable with bit0 clear
    wr(8'h0C, 32'd9);
    bus_wr(8'h04, 32'hFFFF_FFFE, 4'hF, r);
    bus_rd(8'h00, 4'hF, d, r); check("R4 bit0 clear no program", d, w5);

    // R6 programming a 1 still locks the bit (word 6 bit 0)
    wr(8'h08, 32'd6); wr(8'h0C, 32'd0); wr(8'h10, 32'h1);
    wr(8'h04, 32'h1);
    wr(8'h10, 32'h0);
    bus_wr(8'h04, 32'h1, 4'hF, r);
    check("R6 locked after programming one", {31'b0, r}, 32'h1);
    bus_rd(8'h00, 4'hF, d, r); check("R6 word6 unchanged", d, 32'hFFFF_FFFF);

    // R5 top bit index 31 of word 6
    wr(8'h0C, 32'd31);
    wr(8'h04, 32'h1);
    bus_rd(8'h00, 4'hF, d, r); check("R5 bit 31 cleared", d, 32'h7FFF_FFFF);

    // R3 address aliasing above the mask
    wr(8'h08, 32'hFFFF_FF05);
    bus_rd(8'h08, 4'hF, d, r); check("R3 masked address", d, 32'h05);
    bus_rd(8'h00, 4'hF, d, r); check("R3 masked address selects word 5", d, w5);

    // R2 data-out write ignored
    wr(8'h00, 32'h1234_5678);
    bus_rd(8'h00, 4'hF, d, r); check("R2 dout unchanged", d, w5);
    bus_rd(8'h08, 4'hF, d, r); check("R2 address unchanged", d, 32'h05);

    // R9 partial, misaligned and unmapped accesses
    bus_wr(8'h2C, 32'h5555_5555, 4'h3, r);
    bus_rd(8'h2C, 4'hF, d, r); check("R9 partial write dropped", d, 32'h8000_0001);
    bus_rd(8'h2C, 4'h1, d, r); check("R9 partial read zero", d, 32'h0);
    bus_rd(8'h2D, 4'hF, d, r); check("R9 misaligned read zero", d, 32'h0);
    bus_wr(8'h3C, 32'hFFFF_FFFF, 4'hF, r);
    bus_rd(8'h3C, 4'hF, d, r); check("R9 unmapped read zero", d, 32'h0);
    bus_rd(8'h80, 4'hF, d, r); check("R9 far unmapped read zero", d, 32'h0);

    // R11 read data holds while idle
    bus_rd(8'h18, 4'hF, d, r); check("R11 read after one cycle", d, 32'h1);
    wr(8'h18, 32'h1);
    repeat (3) @(negedge clk);
    check("R11 rdata held", rd_val(rdata), 32'h1);

    // R7 mid-run reset
    do_reset;
    bus_rd(8'h00, 4'hF, d, r); check("R7 gate closed after reset", d, 32'hFF);
    bus_rd(8'h2C, 4'hF, d, r); check("R10 test-control cleared", d, 32'h0);
    wr(8'h18, 32'h1); wr(8'h1C, 32'h1); wr(8'h20, 32'h1);
    wr(8'h08, 32'd5);
    bus_rd(8'h00, 4'hF, d, r); check("R7 word restored", d, 32'hFFFF_FFFF);
    wr(8'h0C, 32'd3); wr(8'h10, 32'h0);
    bus_wr(8'h04, 32'h1, 4'hF, r);
    check("R7 flags cleared", {31'b0, r}, 32'h0);
    bus_rd(8'h00, 4'hF, d, r); check("R7 reprogram after reset", d, 32'hFFFF_FFF7);
    wr(8'h08, 32'(SIDX));
    bus_rd(8'h00, 4'hF, d, r); check("R8 serial after second reset", d, SER);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule